// File: doc/BRIEF.md
# Pausable Serial Register Write Port

This block receives register words from a host that drives its own serial clock. The host pulls an active-low frame select low, holds an address line, and shifts in a 24-bit word with the most significant bit first. The port samples one data bit each time the serial clock enters its high phase while the frame select is low. The address line picks the destination: low selects the control register and high selects the calibration registers.

The host may raise the frame select partway through a word, while the serial clock is low, and lower it again later. The port treats this as a pause. It keeps the partial word and its bit position, and it ignores clock pulses that arrive during the pause. When the 24th bit arrives, the port emits a one-cycle write strobe. The assembled word and its destination are valid in that same cycle and stay unchanged until the next strobe.

All host-side inputs pass through two-flop synchronizers into the system clock domain. The system clock must be several times faster than the serial clock. A synchronous reset or an abort input discards any partial word.

Top module: `ser_wr_port`

## Requirements
- R1: After synchronous reset, wr_strobe is 0 and wr_data is 0. A reset in the middle of a word discards the bits already taken, so the next 24 bits form a complete word on their own.
- R2: The port takes exactly 24 bits, MSB first: the first bit taken lands in wr_data[23] and the last in wr_data[0]. On the 24th bit, wr_strobe is high for exactly one system clock cycle. wr_data changes only in a cycle where wr_strobe is high.
- R3: wr_target is 0 (control register) when the address line was low, and 1 (calibration registers) when it was high.
- R4: If ser_frame_n goes high during a serial clock low phase and later returns low, the next serial clock high phase takes the next bit. The word continues from where it stopped, with no restart.
- R5: Serial clock high phases that occur while ser_frame_n is high take no bit and do not advance the bit position.
- R6: Pulsing abort for one system clock cycle discards the partial word and resets the bit position to zero.
- R7: After only 23 bits, no strobe is issued.
- R8: The destination is latched from the address line when the first bit of a word is taken. Later changes to the address line within that word do not change wr_target.
- R9: After a word completes, the bit position returns to zero. A second word sent without releasing ser_frame_n is assembled independently of the first.
- R10: Each serial clock high phase takes exactly one bit, however many system clock cycles that phase lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| abort | input | 1 | Discards the partial word (system clock domain) |
| ser_clk | input | 1 | Serial clock from the host; idles low |
| ser_frame_n | input | 1 | Frame select, active low |
| ser_addr | input | 1 | Destination select: 0 = control, 1 = calibration |
| ser_din | input | 1 | Serial data, MSB first |
| wr_strobe | output | 1 | One-cycle pulse when a word completes |
| wr_target | output | 1 | Destination of the completed word |
| wr_data | output | 24 | Completed word |

## Verification
The risky coincidence is a serial clock rising edge that is qualified in the same system cycle that abort or a word commit also acts on the bit counter. Abort must win, and a commit must reset the counter instead of advancing it. The bench provokes this by aborting right after 23 bits, then sending a fresh word, and by sending two words back to back under one held frame select. In both cases it judges the result by the exact data and the strobe count.

// File: rtl/ser_wr_pkg.sv
`timescale 1ns/1ps
package ser_wr_pkg;
    typedef enum logic {
        TGT_CTRL = 1'b0,
        TGT_CAL  = 1'b1
    } tgt_e;

    localparam int SYNC_STAGES = 2;
    localparam int PIN_COUNT   = 4;
    localparam int PIN_CLK     = 0;
    localparam int PIN_FRAME   = 1;
    localparam int PIN_DIN     = 2;
    localparam int PIN_ADDR    = 3;
endpackage

// File: rtl/ser_wr_sync.sv
`timescale 1ns/1ps
module ser_wr_sync #(
    parameter int          N      = 4,
    parameter int          STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [STAGES-1:0][N-1:0] stg_d;
    logic [STAGES-1:0][N-1:0] stg_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = din;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ser_wr_qual.sv
`timescale 1ns/1ps
module ser_wr_qual (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic frame_n_s,
    output logic cap
);
    typedef struct packed {
        logic prev;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d      = qual_q;
        qual_d.prev = sclk_s;
        cap         = sclk_s & ~qual_q.prev & ~frame_n_s;
    end

    always_ff @(posedge clk) begin
        if (rst) qual_q <= '0;
        else     qual_q <= qual_d;
    end
endmodule

// File: rtl/ser_wr_core.sv
`timescale 1ns/1ps
module ser_wr_core #(
    parameter int W  = 24,
    parameter int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          cap,
    input  logic          bit_in,
    input  logic          addr_in,
    output logic          stb,
    output logic          tgt,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-2:0]  sh;
        logic          tgt;
        logic [W-1:0]  dout;
        logic          tout;
        logic          stb;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d     = core_q;
        core_d.stb = 1'b0;
        if (abort) begin
            core_d.cnt = '0;
            core_d.sh  = '0;
        end else if (cap) begin
            if (core_q.cnt == LAST) begin
                core_d.dout = {core_q.sh, bit_in};
                core_d.tout = core_q.tgt;
                core_d.stb  = 1'b1;
                core_d.cnt  = '0;
                core_d.sh   = '0;
            end else begin
                if (core_q.cnt == '0) core_d.tgt = addr_in;
                core_d.sh  = {core_q.sh[W-3:0], bit_in};
                core_d.cnt = core_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    assign stb  = core_q.stb;
    assign tgt  = core_q.tout;
    assign dout = core_q.dout;
    assign cnt  = core_q.cnt;
endmodule

// File: rtl/ser_wr_port.sv
`timescale 1ns/1ps
module ser_wr_port
    import ser_wr_pkg::*;
#(
    parameter int W  = 24,
    parameter int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         abort,
    input  logic         ser_clk,
    input  logic         ser_frame_n,
    input  logic         ser_addr,
    input  logic         ser_din,
    output logic         wr_strobe,
    output logic         wr_target,
    output logic [W-1:0] wr_data
);
    localparam logic [PIN_COUNT-1:0] PIN_RST = PIN_COUNT'(1) << PIN_FRAME;

    logic [PIN_COUNT-1:0] pins_raw;
    logic [PIN_COUNT-1:0] pins_s;
    logic                 sclk_s;
    logic                 frame_n_s;
    logic                 cap;
    logic [CW-1:0]        bit_cnt;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_CLK]   = ser_clk;
        pins_raw[PIN_FRAME] = ser_frame_n;
        pins_raw[PIN_DIN]   = ser_din;
        pins_raw[PIN_ADDR]  = ser_addr;
    end

    ser_wr_sync #(
        .N(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)
    ) u_sync (
        .clk(clk), .rst(rst), .din(pins_raw), .dout(pins_s)
    );

    assign sclk_s    = pins_s[PIN_CLK];
    assign frame_n_s = pins_s[PIN_FRAME];

    ser_wr_qual u_qual (
        .clk(clk), .rst(rst), .sclk_s(sclk_s), .frame_n_s(frame_n_s), .cap(cap)
    );

    ser_wr_core #(.W(W), .CW(CW)) u_core (
        .clk(clk), .rst(rst), .abort(abort), .cap(cap),
        .bit_in(pins_s[PIN_DIN]), .addr_in(pins_s[PIN_ADDR]),
        .stb(wr_strobe), .tgt(wr_target), .dout(wr_data), .cnt(bit_cnt)
    );
endmodule

// File: rtl/ser_wr_port_chk.sv
`timescale 1ns/1ps
module ser_wr_port_chk #(
    parameter int W  = 24,
    parameter int CW = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic          abort,
    input logic          wr_strobe,
    input logic [W-1:0]  wr_data,
    input logic [CW-1:0] bit_cnt,
    input logic          frame_n_s
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe); // R2
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |-> $stable(wr_data)); // R2
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        abort |=> (bit_cnt == '0)); // R6
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (frame_n_s && !abort) |=> $stable(bit_cnt)); // R5
    AST_COMMIT_WRAPS: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (bit_cnt == '0)); // R9
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        bit_cnt < CW'(W)); // R7
endmodule

bind ser_wr_port ser_wr_port_chk #(.W(W), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .abort(abort), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .bit_cnt(bit_cnt), .frame_n_s(frame_n_s)
);

// File: tb/tb_ser_wr_port.sv
`timescale 1ns/1ps
module tb_ser_wr_port;
    localparam int W = 24;
    localparam int PH = 4;

    typedef struct packed {
        logic         a;
        logic [23:0]  d;
        logic [4:0]   p;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 24'hA5C3F0, 5'd0},
        '{1'b1, 24'h123456, 5'd0},
        '{1'b0, 24'hFFFFFF, 5'd7},
        '{1'b1, 24'h800001, 5'd12},
        '{1'b1, 24'h000000, 5'd23},
        '{1'b0, 24'h5A5A5A, 5'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic abort = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_frame_n = 1'b1;
    logic ser_addr = 1'b0;
    logic ser_din = 1'b0;
    logic wr_strobe;
    logic wr_target;
    logic [W-1:0] wr_data;

    int errors = 0;
    int checks = 0;
    int stb_cnt = 0;
    int multi = 0;
    logic prev_stb = 1'b0;
    logic [W-1:0] last_d = '0;
    logic last_t = 1'b0;

    always #5 clk = ~clk;

    ser_wr_port dut (
        .clk(clk), .rst(rst), .abort(abort), .ser_clk(ser_clk),
        .ser_frame_n(ser_frame_n), .ser_addr(ser_addr), .ser_din(ser_din),
        .wr_strobe(wr_strobe), .wr_target(wr_target), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (!rst && wr_strobe) begin
            stb_cnt = stb_cnt + 1;
            last_d  = wr_data;
            last_t  = wr_target;
            if (prev_stb) multi = multi + 1;
        end
        prev_stb = wr_strobe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic b, input int hi);
        ser_din = b;
        cyc(PH);
        ser_clk = 1'b1;
        cyc(hi);
        ser_clk = 1'b0;
    endtask

    task automatic send_bits(input logic a, input logic [23:0] d, input int nbits,
                             input int pause_at, input int hi);
        ser_addr = a;
        ser_frame_n = 1'b0;
        for (int k = 0; k < nbits; k++) begin
            if (pause_at != 0 && k == pause_at) begin
                cyc(1);
                ser_frame_n = 1'b1;
                cyc(PH);
                pulse(1'b1, PH);
                pulse(1'b0, PH);
                cyc(PH);
                ser_frame_n = 1'b0;
            end
            pulse(d[23-k], hi);
        end
        cyc(PH);
    endtask

    task automatic check_word(input string req, input int pre, input logic a, input logic [23:0] d);
        cyc(10);
        chk(stb_cnt == pre + 1, req, stb_cnt, pre + 1);
        chk(last_d == d, req, last_d, d);
        chk(last_t == a, "R3", last_t, a);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int pre;
        cyc(5);
        chk(wr_strobe == 1'b0, "R1", wr_strobe, 0);
        chk(wr_data == '0, "R1", wr_data, 0);
        rst = 1'b0;
        cyc(4);
        chk(wr_strobe == 1'b0 && wr_data == '0, "R1", wr_data, 0);

        // table walk: R2 MSB-first capture, R3 target, R4 pauses
        for (int i = 0; i < NV; i++) begin
            pre = stb_cnt;
            send_bits(VEC[i].a, VEC[i].d, 24, int'(VEC[i].p), PH);
            ser_frame_n = 1'b1;
            check_word((VEC[i].p != 0) ? "R4" : "R2", pre, VEC[i].a, VEC[i].d);
        end

        // R5: clock pulses with frame high take nothing
        pre = stb_cnt;
        for (int k = 0; k < 30; k++) pulse(1'b1, PH);
        cyc(10);
        chk(stb_cnt == pre, "R5", stb_cnt, pre);
        send_bits(1'b0, 24'h0F1E2D, 24, 0, PH);
        ser_frame_n = 1'b1;
        check_word("R5", pre, 1'b0, 24'h0F1E2D);

        // R7: 23 bits give no strobe; R6: abort discards them
        pre = stb_cnt;
        send_bits(1'b1, 24'hFFFFFF, 23, 0, PH);
        cyc(10);
        chk(stb_cnt == pre, "R7", stb_cnt, pre);
        abort = 1'b1;
        cyc(1);
        abort = 1'b0;
        send_bits(1'b0, 24'h3C3C3C, 24, 0, PH);
        ser_frame_n = 1'b1;
        check_word("R6", pre, 1'b0, 24'h3C3C3C);

        // R1: reset mid-word discards partial bits
        pre = stb_cnt;
        send_bits(1'b1, 24'hFFFFFF, 10, 0, PH);
        ser_frame_n = 1'b1;
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(4);
        chk(wr_data == '0, "R1", wr_data, 0);
        pre = stb_cnt;
        send_bits(1'b1, 24'hC0FFEE, 24, 0, PH);
        ser_frame_n = 1'b1;
        check_word("R1", pre, 1'b1, 24'hC0FFEE);

        // R8: address changes after the first bit are ignored
        pre = stb_cnt;
        ser_addr = 1'b1;
        ser_frame_n = 1'b0;
        pulse(1'b1, PH);
        ser_addr = 1'b0;
        for (int k = 1; k < 24; k++) pulse(k[0], PH);
        cyc(PH);
        ser_frame_n = 1'b1;
        check_word("R8", pre, 1'b1, 24'hD55555);

        // R9: two words back to back under one frame
        pre = stb_cnt;
        send_bits(1'b0, 24'h111111, 24, 0, PH);
        cyc(10);
        chk(stb_cnt == pre + 1 && last_d == 24'h111111, "R9", last_d, 24'h111111);
        send_bits(1'b0, 24'hEEEEEE, 24, 0, PH);
        ser_frame_n = 1'b1;
        check_word("R9", pre + 1, 1'b0, 24'hEEEEEE);

        // R10: long high phases take one bit each
        pre = stb_cnt;
        send_bits(1'b1, 24'h9ABCDE, 24, 0, 20);
        ser_frame_n = 1'b1;
        check_word("R10", pre, 1'b1, 24'h9ABCDE);

        chk(multi == 0, "R2", multi, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule